// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Bank

This block is the digital front end of a four-channel, 12-bit parallel-input converter. It is modelled synchronously, with every control sampled on the rising clock edge. Each channel has two registers. A host writes a code into a channel's input register over the data bus. A load strobe then moves all input registers into the output registers in the same cycle, and the output registers feed the four converters. The host can also read back any input register over the same bus.

The bidirectional bus is split into a data input, a registered data output and an output enable. An external pad drives the bus only while the enable is high. The value that reset places in every register comes from a parameter: midscale (0x800) suits bipolar reference setups, and zero suits unipolar ones.

Top module: `dacbank_top`

## Requirements
- R1: While `rst` is high at a clock edge, every input and output register takes the reset code and `data_oe` goes low. The reset code is 0x800 when RESET_MID=1 (the default) and 0x000 when RESET_MID=0. A readback after reset returns that code.
- R2: The select code on `addr` picks the channel: 0 is channel 0 (A), 1 is channel 1 (B), 2 is channel 2 (C) and 3 is channel 3 (D). With `cs_n`=0 and `rw`=0 at an edge, `data_in` is written into the selected input register only. With `load_n`=1, no output changes.
- R3: With `cs_n`=1 at an edge, the write, read and load controls have no effect. No input register changes, `chan_out` stays stable and `data_oe` is low in the next cycle.
- R4: With `cs_n`=0 and `rw`=1 at an edge, the next cycle shows `data_oe`=1 and `data_out` equal to the selected input register as it stood at that edge. In every other cycle `data_oe`=0 and `data_out`=0.
- R5: With `cs_n`=0 and `load_n`=0 at an edge, every output register takes its channel's input register value in the next cycle. With `load_n`=1, `chan_out` stays stable.
- R6: When a write (`cs_n`=0, `rw`=0) and a load (`load_n`=0) fall in the same cycle, both ranks of the selected channel pass the written value, so it appears on that channel's output in the next cycle. The other channels load their input registers.
- R7: Reset takes priority over any write, read or load sampled in the same cycle.
- R8: Codes are straight binary. Bit 11 is the MSB and bit 0 the LSB on `data_in`, `data_out` and each channel slice. Channel k occupies `chan_out[k*12+11 : k*12]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the variant's reset code |
| cs_n | input | 1 | Chip select, active low; enables decoding |
| rw | input | 1 | 1 = read back the selected input register, 0 = write it |
| addr | input | 2 | Channel select code |
| load_n | input | 1 | Load strobe, active low; transfers all input registers to the output registers |
| data_in | input | 12 | Bus value presented by the host |
| data_out | output | 12 | Registered readback value; zero when not driving |
| data_oe | output | 1 | High when the bus must be driven with `data_out` |
| chan_out | output | 48 | Four output-register codes, channel k in bits k*12 +: 12 |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge and holds steady around that edge. They also assume that `rst` is high from time zero through the first edge. The stimulus changes inputs only on the falling edge and holds reset high for the opening cycles. It draws every control and data value from the full legal range, so no input is ever left unknown. Reset is reapplied only as a synchronous level, never as a glitch within a cycle.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

  typedef struct packed {
    logic wr;
    logic rd;
    logic ld;
  } bus_cmd_t;

  function automatic logic [31:0] reset_code(input int unsigned width, input bit mid);
    return mid ? (32'd1 << (width - 1)) : 32'd0;
  endfunction

endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              cs_n,
  input  logic              rw,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] addr,
  output bus_cmd_t          cmd,
  output logic [NUM_CH-1:0] wr_sel
);

  always_comb begin
    cmd.wr = !cs_n && !rw;
    cmd.rd = !cs_n && rw;
    cmd.ld = !cs_n && !load_n;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign wr_sel[k] = cmd.wr && (addr == ADDR_W'(k));
  end

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int              DATA_W  = 12,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= RST_VAL;
      out_q <= RST_VAL;
    end else begin
      if (wr_en) in_q <= din;
      if (ld_en) out_q <= wr_en ? din : in_q;
    end
  end

endmodule

// File: rtl/dacbank_readmux.sv
module dacbank_readmux #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*DATA_W-1:0] in_flat,
  output logic [DATA_W-1:0]        data_out,
  output logic                     data_oe
);

  logic [DATA_W-1:0] picked;

  always_comb picked = in_flat[addr*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_oe  <= rd_en;
      data_out <= rd_en ? picked : '0;
    end
  end

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = $clog2(NUM_CH),
  parameter bit RESET_MID = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     rw,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     load_n,
  input  logic [DATA_W-1:0]        data_in,
  output logic [DATA_W-1:0]        data_out,
  output logic                     data_oe,
  output logic [NUM_CH*DATA_W-1:0] chan_out
);

  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_code(DATA_W, RESET_MID));

  bus_cmd_t              cmd;
  logic [NUM_CH-1:0]     wr_sel;
  logic [NUM_CH*DATA_W-1:0] in_flat;

  dacbank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) decode_i (
    .cs_n   (cs_n),
    .rw     (rw),
    .load_n (load_n),
    .addr   (addr),
    .cmd    (cmd),
    .wr_sel (wr_sel)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    dacbank_chan #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) chan_i (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_sel[k]),
      .ld_en (cmd.ld),
      .din   (data_in),
      .in_q  (in_flat[k*DATA_W +: DATA_W]),
      .out_q (chan_out[k*DATA_W +: DATA_W])
    );
  end

  dacbank_readmux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) readmux_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (cmd.rd),
    .addr     (addr),
    .in_flat  (in_flat),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
  parameter int DATA_W    = 12,
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = $clog2(NUM_CH),
  parameter bit RESET_MID = 1'b1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_n,
  input logic                     rw,
  input logic [ADDR_W-1:0]        addr,
  input logic                     load_n,
  input logic [DATA_W-1:0]        data_in,
  input logic [DATA_W-1:0]        data_out,
  input logic                     data_oe,
  input logic [NUM_CH*DATA_W-1:0] chan_out
);

  localparam logic [DATA_W-1:0] RST_CODE =
    RESET_MID ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  assert_reset_code_R1: assert property (@(posedge clk)
    rst |=> (chan_out == {NUM_CH{RST_CODE}}) && !data_oe);

  assert_reset_wins_R7: assert property (@(posedge clk)
    (rst && !cs_n) |=> (chan_out == {NUM_CH{RST_CODE}}) && (data_out == '0));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(chan_out) && !data_oe);

  assert_read_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rw) |=> data_oe);

  assert_bus_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  assert_no_load_hold_R5: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(chan_out));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_tr
    assert_transparent_R6: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !rw && !load_n && (addr == ADDR_W'(k)))
      |=> (chan_out[k*DATA_W +: DATA_W] == $past(data_in)));
  end

endmodule

bind dacbank_top dacbank_chk #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RESET_MID(RESET_MID)
) chk_i (.*);

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;

  localparam int DW = 12;
  localparam int NC = 4;
  localparam int AW = 2;
  localparam logic [DW-1:0] MID = 12'h800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, cs_n = 1'b1, rw = 1'b1, load_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;

  logic [DW-1:0]    dout, dout_z;
  logic             oe, oe_z;
  logic [NC*DW-1:0] chans, chans_z;

  dacbank_top #(.DATA_W(DW), .NUM_CH(NC), .RESET_MID(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .load_n(load_n),
    .data_in(din), .data_out(dout), .data_oe(oe), .chan_out(chans));

  dacbank_top #(.DATA_W(DW), .NUM_CH(NC), .RESET_MID(1'b0)) dut_z_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .load_n(load_n),
    .data_in(din), .data_out(dout_z), .data_oe(oe_z), .chan_out(chans_z));

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] m_in [NC];
  logic [DW-1:0] m_out [NC];
  logic [DW-1:0] m_rd = '0;
  logic          m_oe = 1'b0;

  task automatic drive(input logic r, input logic c, input logic w, input logic l,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    rst = r; cs_n = c; rw = w; load_n = l; addr = a; din = d;
  endtask

  task automatic step(input string tag);
    logic [DW-1:0] nx [NC];
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < NC; k++) begin m_in[k] = MID; m_out[k] = MID; end
      m_rd = '0; m_oe = 1'b0;
    end else begin
      for (int k = 0; k < NC; k++) nx[k] = m_in[k];
      if (!cs_n && !rw) nx[addr] = din;
      m_oe = !cs_n && rw;
      m_rd = m_oe ? m_in[addr] : '0;
      if (!cs_n && !load_n) for (int k = 0; k < NC; k++) m_out[k] = nx[k];
      for (int k = 0; k < NC; k++) m_in[k] = nx[k];
    end
    @(negedge clk);
    vectors++;
    for (int k = 0; k < NC; k++)
      if (chans[k*DW +: DW] !== m_out[k]) begin
        miscompares++;
        $display("FAIL %s ch%0d output actual=%h expected=%h", tag, k, chans[k*DW +: DW], m_out[k]);
      end
    if (oe !== m_oe) begin
      miscompares++;
      $display("FAIL %s data_oe actual=%b expected=%b", tag, oe, m_oe);
    end
    if (dout !== m_rd) begin
      miscompares++;
      $display("FAIL %s data_out actual=%h expected=%h", tag, dout, m_rd);
    end
  endtask

  task automatic check_zero(input string tag);
    vectors++;
    if (chans_z !== '0 || oe_z !== 1'b0) begin
      miscompares++;
      $display("FAIL %s zero variant actual=%h/%b expected=%h/0", tag, chans_z, oe_z, {NC*DW{1'b0}});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state in both variants
    step("R1"); step("R1");
    check_zero("R1");
    // R1: readback of input register during reset release
    drive(0, 0, 1, 1, 2'd2, '0); step("R1");
    if (dout_z !== '0) begin
      miscompares++;
      $display("FAIL R1 zero variant readback actual=%h expected=000", dout_z);
    end
    vectors++;
    // R3: deselected write, read and load do nothing
    drive(0, 1, 0, 0, 2'd1, 12'h123); step("R3");
    drive(0, 1, 1, 0, 2'd1, 12'h456); step("R3");
    drive(0, 0, 1, 1, 2'd1, '0);      step("R3");
    // R2: write each channel, outputs unchanged
    drive(0, 0, 0, 1, 2'd0, 12'h111); step("R2");
    drive(0, 0, 0, 1, 2'd1, 12'h2A2); step("R2");
    drive(0, 0, 0, 1, 2'd2, 12'h353); step("R2");
    drive(0, 0, 0, 1, 2'd3, 12'hF04); step("R2");
    // R4: read back each channel
    for (int k = 0; k < NC; k++) begin drive(0, 0, 1, 1, AW'(k), 12'hFFF); step("R4"); end
    drive(0, 0, 0, 1, 2'd0, 12'h111); step("R4");
    // R5: load all while reading
    drive(0, 0, 1, 0, 2'd3, '0); step("R5");
    drive(0, 1, 1, 1, 2'd0, '0); step("R5");
    // R3: load strobe ignored while deselected
    drive(0, 0, 0, 1, 2'd1, 12'h777); step("R3");
    drive(0, 1, 1, 0, 2'd1, '0);      step("R3");
    // R6: write with load passes straight through
    drive(0, 0, 0, 0, 2'd3, 12'hABC); step("R6");
    drive(0, 0, 1, 1, 2'd3, '0);      step("R6");
    // R8: MSB and LSB positions
    drive(0, 0, 0, 0, 2'd0, 12'h801); step("R8");
    drive(0, 0, 0, 0, 2'd2, 12'h7FE); step("R8");
    drive(0, 0, 1, 1, 2'd0, '0);      step("R8");
    // R7: reset beats write and load, and beats read
    drive(1, 0, 0, 0, 2'd1, 12'h5A5); step("R7");
    check_zero("R7");
    drive(1, 0, 1, 1, 2'd1, '0);      step("R7");
    for (int k = 0; k < NC; k++) begin drive(0, 0, 1, 1, AW'(k), '0); step("R7"); end
    // R5: mixed traffic
    for (int i = 0; i < 400; i++) begin
      drive(($urandom_range(0, 39) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
            AW'($urandom), DW'($urandom));
      step("R5");
    end
    drive(0, 1, 1, 1, '0, '0); step("R3");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule